// File: doc/BRIEF.md
# Receive Loss-of-Signal and Recovered-Clock Squelch

This block decides whether a line receiver has lost its input signal. It watches the recovered data stream for long runs of zeros and merges that digital verdict with a flag from an external analog amplitude detector. The recovered clock comes from a free-running oscillator, so it keeps toggling after the line goes quiet. The block can therefore gate off that clock, and force the recovered data low, for as long as the loss condition lasts.

Two controls shape the result. A loopback select makes the digital zero-run verdict the only source of the loss flag, because the analog detector does not see a looped signal. A squelch enable decides whether a loss suppresses the clock and the data. The gated clock is produced with a latch that is open on the low clock phase, so it never emits a shortened pulse.

Top module: `rx_los_squelch`

## Requirements
- R1: After a synchronous active-low reset, the zero-run count is zero, `los` is 0, `clk_en` is 1 and data passes through.
- R2: The digital detector asserts after the 33rd consecutive zero that is clocked in. A run of exactly 32 zeros leaves `los` at 0.
- R3: A one clocked in clears the zero-run count, and the digital detector drops at that clock edge.
- R4: The zero-run count saturates, so `los` stays asserted through an arbitrarily long run of zeros and clears on the first one.
- R5: When loopback is 0, `los` is the OR of the digital detector and the analog flag. The analog flag passes through a two-flop synchronizer, so `los` follows it two rising edges later.
- R6: When loopback is 1, `los` equals the digital detector and the analog flag has no effect.
- R7: When `squelch_en` is 1 and `los` is 1, `clk_en` is 0 and `clk_gated` produces no rising edges.
- R8: `data_out` equals `rx_data` while the clock is enabled. It is forced to 0 while the clock is squelched.
- R9: When `squelch_en` is 0, the clock and the data pass through even while `los` is 1.
- R10: `clk_gated` gives one full rising edge for each recovered-clock cycle whose enable was 1 during the preceding low phase, and no other edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock from the oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 1 | Recovered data bit |
| ana_loss | input | 1 | Asynchronous analog low-amplitude flag |
| loop_sel | input | 1 | 1 = loopback, analog flag ignored |
| squelch_en | input | 1 | 1 = suppress clock and data on loss |
| los | output | 1 | Loss-of-signal indication |
| clk_en | output | 1 | Clock enable before the latch (0 = squelch) |
| clk_gated | output | 1 | Glitch-free gated recovered clock |
| data_out | output | 1 | Recovered data, forced to 0 while squelched |

## Verification
A zero-run count that is off by one moves the rise of `los` by one cycle. This shows on the 33rd zero, or on the cycle just after it. A count that does not saturate or does not clear shows as `los` dropping inside a long zero run, or staying high one cycle after a one. A wrong synchronizer depth or a wrong loopback mux shows on `los` within two edges of a change of the analog flag. A wrong gating enable shows as a gated-clock edge count that no longer matches the enable history on the next edge.

// File: rtl/rx_los_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the loss-of-signal block.
// Assumes: single recovered-clock domain; the analog flag is the only async input.
package rx_los_pkg;

    typedef enum logic {
        LINE_NORMAL   = 1'b0,
        LINE_LOOPBACK = 1'b1
    } line_mode_e;

    // Merge the two detectors according to the line mode.
    function automatic logic merge_loss(input logic dig, input logic ana, input line_mode_e mode);
        return (mode == LINE_LOOPBACK) ? dig : (dig | ana);
    endfunction

endpackage

// File: rtl/rx_zero_run.sv
`timescale 1ns/1ps
// Counts consecutive zeros on the recovered data and flags a run longer than ZERO_LIMIT.
// Assumes: rx_data is sampled on the rising clock edge; the count saturates at ZERO_LIMIT+1.
module rx_zero_run #(
    parameter int ZERO_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_data,
    output logic dig_loss
);
    localparam int SAT_VAL = ZERO_LIMIT + 1;
    localparam int CW      = $clog2(SAT_VAL + 1);

    logic [CW-1:0] run_q;

    // Zero-run counter: clear on a one, count up on a zero, hold at saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (rx_data)
            run_q <= '0;
        else if (run_q != CW'(SAT_VAL))
            run_q <= run_q + 1'b1;
    end

    assign dig_loss = (run_q == CW'(SAT_VAL));

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(SAT_VAL)); // R4
    AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_data) |-> !dig_loss); // R3
    AST_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dig_loss) |-> !$past(rx_data)); // R2

endmodule

// File: rtl/rx_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for the asynchronous analog loss flag.
// Assumes: the input stays stable for at least two recovered-clock cycles.
module rx_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [1:0] stage_q;

    // Shift the flag through two stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= {stage_q[0], async_in};
    end

    assign sync_out = stage_q[1];

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage_q[0] == $past(async_in))); // R5
    AST_SYNC_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_out == $past(stage_q[0]))); // R5

endmodule

// File: rtl/rx_clk_gate.sv
`timescale 1ns/1ps
// Glitch-free clock gate: the enable is captured by a latch that is open while clk is low.
// Assumes: en settles during the low phase; en_q is stable during the high phase.
module rx_clk_gate (
    input  logic clk,
    input  logic en,
    output logic en_q,
    output logic gclk
);
    // Capture the enable on the low phase only.
    always_latch begin
        if (!clk)
            en_q = en;
    end

    assign gclk = clk & en_q;

endmodule

// File: rtl/rx_los_squelch.sv
`timescale 1ns/1ps
// Loss-of-signal detection and recovered-clock squelch for a line receiver.
// Assumes: clk is the free-running recovered clock; ana_loss is asynchronous to it.
module rx_los_squelch
    import rx_los_pkg::*;
#(
    parameter int ZERO_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_data,
    input  logic ana_loss,
    input  logic loop_sel,
    input  logic squelch_en,
    output logic los,
    output logic clk_en,
    output logic clk_gated,
    output logic data_out
);
    logic       dig_loss;
    logic       ana_sync;
    logic       en_latched;
    line_mode_e mode;

    rx_zero_run #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_data  (rx_data),
        .dig_loss (dig_loss)
    );

    rx_sync2 u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ana_loss),
        .sync_out (ana_sync)
    );

    // Select the detector merge mode and form the loss flag and the enable.
    always_comb begin
        mode   = loop_sel ? LINE_LOOPBACK : LINE_NORMAL;
        los    = merge_loss(dig_loss, ana_sync, mode);
        clk_en = !(squelch_en && los);
    end

    rx_clk_gate u_gate (
        .clk  (clk),
        .en   (clk_en),
        .en_q (en_latched),
        .gclk (clk_gated)
    );

    // Force the data low whenever the gated clock is held off.
    always_comb begin
        data_out = rx_data & en_latched;
        AST_DATA_SQUELCHED: assert (en_latched !== 1'b0 || data_out == 1'b0); // R8
    end

    AST_LOOP_DIG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        loop_sel |-> (los == dig_loss)); // R6
    AST_ANALOG_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_sel && ana_sync) |-> los); // R5
    AST_SQUELCH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (squelch_en && los) |-> !clk_en); // R7
    AST_NO_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
        !squelch_en |-> clk_en); // R9

endmodule

// File: tb/rx_los_squelch_tb.sv
`timescale 1ns/1ps
module rx_los_squelch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 32;

    logic clk = 0, rst_n = 0, rx_data = 0, ana_loss = 0, loop_sel = 0, squelch_en = 0;
    logic los, clk_en, clk_gated, data_out;

    rx_los_squelch #(.ZERO_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .ana_loss(ana_loss),
        .loop_sel(loop_sel), .squelch_en(squelch_en),
        .los(los), .clk_en(clk_en), .clk_gated(clk_gated), .data_out(data_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic  los;
        logic  en;
        logic  dat;
        string tag;
    } exp_t;

    exp_t sbq[$];
    exp_t cur;
    int   tests = 0, fails = 0;
    int   gcnt = 0, exp_edges = 0;
    bit   gcnt_on = 0;

    // Reference model state
    int   m_run = 0;
    logic m_a1 = 0, m_a2 = 0;
    logic p_rst = 0, p_dat = 0, p_ana = 0;

    always @(posedge clk_gated) if (gcnt_on) gcnt++;

    // Driver: one recovered-clock cycle of stimulus plus the expected outputs.
    task automatic step(input logic d, input logic a, input logic lp, input logic sq,
                        input logic r, input string tag);
        logic dig, l, sqz;
        @(posedge clk); #1;
        tests++;
        if (gcnt != exp_edges) begin
            fails++;
            $display("FAIL R10 gated clock edges actual %0d expected %0d", gcnt, exp_edges);
        end
        if (!p_rst) begin
            m_run = 0; m_a1 = 0; m_a2 = 0;
        end else begin
            m_a2 = m_a1;
            m_a1 = p_ana;
            m_run = p_dat ? 0 : ((m_run < LIMIT + 1) ? m_run + 1 : m_run);
        end
        rx_data = d; ana_loss = a; loop_sel = lp; squelch_en = sq; rst_n = r;
        p_rst = r; p_dat = d; p_ana = a;
        dig = (m_run > LIMIT);
        l   = lp ? dig : (dig | m_a2);
        sqz = sq & l;
        sbq.push_back('{l, !sqz, d & !sqz, tag});
        exp_edges += int'(!sqz);
        gcnt_on = 1;
    endtask

    task automatic repeat_step(input int n, input logic d, input logic a, input logic lp,
                               input logic sq, input string tag);
        for (int i = 0; i < n; i++) step(d, a, lp, sq, 1'b1, tag);
    endtask

    // Monitor: pop and compare at the falling edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            cur = sbq.pop_front();
            tests += 3;
            if (los !== cur.los) begin
                fails++;
                $display("FAIL %s los actual %b expected %b", cur.tag, los, cur.los);
            end
            if (clk_en !== cur.en) begin
                fails++;
                $display("FAIL %s clk_en actual %b expected %b", cur.tag, clk_en, cur.en);
            end
            if (data_out !== cur.dat) begin
                fails++;
                $display("FAIL %s data_out actual %b expected %b", cur.tag, data_out, cur.dat);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL R1 watchdog actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
        repeat_step(2, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        // R8 data passes with mixed pattern
        for (int i = 0; i < 10; i++) step(logic'(i % 2), 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        // R2 boundary: exactly 32 zeros, no loss
        repeat_step(32, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
        repeat_step(3, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        // R2 / R7 40 zeros with squelch on
        repeat_step(40, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
        // R8 first one still squelched, R3 then clears
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        repeat_step(3, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
        // R4 / R9 long saturated run, squelch off
        repeat_step(100, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        repeat_step(2, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        // R5 analog flag in normal mode, squelch on
        repeat_step(5, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        // R6 loopback ignores analog
        repeat_step(5, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
        repeat_step(4, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        // R6 loopback uses digital detector
        repeat_step(36, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
        repeat_step(2, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
        repeat_step(3, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
        // R1 reset during a zero run
        repeat_step(36, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
        repeat_step(4, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
        repeat_step(3, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        @(negedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule